// File: doc/BRIEF.md
# Gate-Scheduled Transmit Fill Arbiter

This block decides, once the egress wire is idle, which of eight queued traffic priorities may start the next frame on one port. It walks a list of timed gate entries. Each entry carries a duration in clocks and an eight-bit mask of the priorities allowed to send while that entry is active. An entry whose mask is all zero marks a guard interval. During a guard interval the wire drains ahead of the next timed window.

When the fill option is on, the guard interval is not always left empty. The arbiter may admit a short frame from a priority that was not timed in the last open window, but only if that frame finishes early enough. Its wire time plus a programmable safety margin must fit inside the clocks still left in the guard entry. Fill is used only when the last non-empty mask held a single traffic class, either all express or all preemptable. A frame's wire time is its byte length plus 20 bytes of preamble and inter-frame gap, multiplied by a clocks-per-byte factor chosen by the link speed.

The gate-list store sits outside this block. The arbiter raises `fetch_req` in every cycle where it loads a new entry, and the entry must be on `ent_count`/`ent_allow` in that cycle.

Top module: `gate_fill_arb`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `grant` is zero and `start` is low. `fetch_req` is high, because the remaining count resets to zero.
- R2: When the remaining count is zero, `fetch_req` is high and the entry on the inputs is loaded. The count then drops by one each clock, so a loaded count N raises `fetch_req` again N clocks after the load edge.
- R3: In an entry with a non-zero allow mask, the arbiter picks the highest-numbered priority that is both valid and allowed. It does this only while the wire is idle and the remaining count is non-zero. With the wire idle, the result appears on `grant`/`start` one clock after the decision.
- R4: `start` is a one-clock pulse. While it is high, `grant` is one-hot with bit p for priority p. At all other times `grant` is zero.
- R5: After a start, the next start comes no sooner than W clocks later, where W = (length + 20) × clocks-per-byte of the granted frame. The next start comes exactly W clocks later if an eligible request is still waiting.
- R6: `link_speed` sets clocks-per-byte: 0 gives 1 (gigabit), 1 gives 10 (100 Mb/s), and 2 or 3 give 100 (10 Mb/s).
- R7: With `fill_en` low, an entry whose allow mask is zero grants nothing for its whole count.
- R8: With `fill_en` high, in a zero-mask entry, priority p is a fill candidate when three things hold: it is valid, it is not in the last non-zero allow mask, and W(p) + `fill_margin` ≤ the remaining count in the decision cycle. A frame that misses this check by one clock is never admitted.
- R9: Fill applies only if the last non-zero mask held only express priorities or only preemptable ones. A priority is express where `express_mask` has a 1. If that mask mixed both classes, or no non-zero mask has been loaded since reset, the zero-mask entry grants nothing.
- R10: Among fill candidates, the highest-numbered one that fits wins. A higher-numbered priority whose frame is too long is passed over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | output | 1 | High when the entry on the inputs is loaded this cycle |
| ent_count | input | 16 | Duration of the presented entry, in clocks |
| ent_allow | input | 8 | Allow mask of the presented entry |
| q_valid | input | 8 | Head-of-queue frame present, per priority |
| q_len | input | 88 | Head-of-queue byte length, 11 bits per priority, priority p in bits [11p+10:11p] |
| link_speed | input | 2 | Speed select: 0 gigabit, 1 100 Mb/s, 2/3 10 Mb/s |
| fill_en | input | 1 | Enables fill in zero-mask entries |
| fill_margin | input | 10 | Safety margin in clocks added to a fill frame's wire time |
| express_mask | input | 8 | Per-priority class: 1 express, 0 preemptable |
| grant | output | 8 | One-hot granted priority, valid with start |
| start | output | 1 | One-clock pulse: the granted frame starts |

## Verification
The embedded assertions check several properties on every cycle. They check the count reload and step-down, the one-hot grant shape, and that no start follows a cycle with a busy wire or an exhausted count. They also check that a grant in an open window lies inside that window's mask, and that a fill grant only follows an enabled, single-class guard interval. The bench scenarios alone show the decisions that need computed values. These are which priority wins, the exact start spacing at each speed factor, and the fill fit boundary where one clock decides admission. The bench also covers exclusion of priorities that were timed in the last window, and skipping a too-long higher priority.

// File: rtl/gate_fill_pkg.sv
package gate_fill_pkg;

  // Bytes of preamble plus inter-frame gap added to every frame.
  localparam int unsigned WIRE_OVERHEAD = 20;

  typedef enum logic [1:0] {
    SPD_GIG     = 2'd0,
    SPD_100M    = 2'd1,
    SPD_10M     = 2'd2,
    SPD_10M_ALT = 2'd3
  } link_speed_e;

endpackage

// File: rtl/gfa_wire_time.sv
module gfa_wire_time
  import gate_fill_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int WT_W  = LEN_W + 7
) (
  input  logic [LEN_W-1:0] len,
  input  logic [1:0]       speed,
  output logic [WT_W-1:0]  wt
);

  logic [WT_W-1:0] bytes_on_wire;

  always_comb begin
    bytes_on_wire = WT_W'(len) + WT_W'(WIRE_OVERHEAD);
    case (link_speed_e'(speed))
      SPD_GIG:  wt = bytes_on_wire;
      SPD_100M: wt = WT_W'(bytes_on_wire * WT_W'(10));
      default:  wt = WT_W'(bytes_on_wire * WT_W'(100));
    endcase
  end

endmodule

// File: rtl/gfa_prio_pick.sv
module gfa_prio_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [N-1:0] onehot
);

  always_comb begin
    onehot = '0;
    for (int p = 0; p < N; p++) begin
      if (req[p]) onehot = N'(1) << p;
    end
    any = |req;
  end

endmodule

// File: rtl/gfa_sched.sv
module gfa_sched #(
  parameter int CNT_W = 16,
  parameter int NPRIO = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] ent_count,
  input  logic [NPRIO-1:0] ent_allow,
  input  logic [NPRIO-1:0] express_mask,
  output logic             fetch_req,
  output logic [CNT_W-1:0] rem,
  output logic [NPRIO-1:0] cur_allow,
  output logic [NPRIO-1:0] last_open,
  output logic             single_class
);

  assign fetch_req = (rem == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem       <= '0;
      cur_allow <= '0;
      last_open <= '0;
    end else if (fetch_req) begin
      rem       <= ent_count;
      cur_allow <= ent_allow;
      if (ent_allow != '0) last_open <= ent_allow;
    end else begin
      rem <= rem - CNT_W'(1);
    end
  end

  assign single_class = (last_open != '0) &&
                        (((last_open & ~express_mask) == '0) ||
                         ((last_open & express_mask) == '0));

  AST_ENTRY_RELOAD: assert property (@(posedge clk) disable iff (rst)
    fetch_req |=> (rem == $past(ent_count))); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !fetch_req |=> (rem == $past(rem) - CNT_W'(1))); // R2

endmodule

// File: rtl/gate_fill_arb.sv
module gate_fill_arb #(
  parameter int NPRIO    = 8,
  parameter int CNT_W    = 16,
  parameter int LEN_W    = 11,
  parameter int MARGIN_W = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  output logic                   fetch_req,
  input  logic [CNT_W-1:0]       ent_count,
  input  logic [NPRIO-1:0]       ent_allow,
  input  logic [NPRIO-1:0]       q_valid,
  input  logic [NPRIO*LEN_W-1:0] q_len,
  input  logic [1:0]             link_speed,
  input  logic                   fill_en,
  input  logic [MARGIN_W-1:0]    fill_margin,
  input  logic [NPRIO-1:0]       express_mask,
  output logic [NPRIO-1:0]       grant,
  output logic                   start
);

  localparam int WT_W  = LEN_W + 7;
  localparam int CMP_W = ((WT_W > CNT_W) ? WT_W : CNT_W) + 2;

  logic [CNT_W-1:0] rem;
  logic [NPRIO-1:0] cur_allow, last_open;
  logic             single_class;

  gfa_sched #(.CNT_W(CNT_W), .NPRIO(NPRIO)) u_sched (
    .clk         (clk),
    .rst         (rst),
    .ent_count   (ent_count),
    .ent_allow   (ent_allow),
    .express_mask(express_mask),
    .fetch_req   (fetch_req),
    .rem         (rem),
    .cur_allow   (cur_allow),
    .last_open   (last_open),
    .single_class(single_class)
  );

  logic [WT_W-1:0]  wt [NPRIO];
  logic [NPRIO-1:0] fits;
  logic [NPRIO-1:0] pick_oh;

  for (genvar p = 0; p < NPRIO; p++) begin : g_prio
    gfa_wire_time #(.LEN_W(LEN_W), .WT_W(WT_W)) u_wt (
      .len  (q_len[p*LEN_W +: LEN_W]),
      .speed(link_speed),
      .wt   (wt[p])
    );
    assign fits[p] = (CMP_W'(wt[p]) + CMP_W'(fill_margin)) <= CMP_W'(rem);
  end

  logic [WT_W-1:0]  busy;
  logic             guard_entry, fill_ok, wire_ready;
  logic [NPRIO-1:0] req;
  logic             pick_any;
  logic [WT_W-1:0]  sel_wt;

  assign guard_entry = (cur_allow == '0);
  assign fill_ok     = fill_en && guard_entry && single_class;
  assign wire_ready  = (busy == '0) && (rem != '0);

  always_comb begin
    req = '0;
    if (wire_ready) begin
      if (!guard_entry) req = q_valid & cur_allow;
      else if (fill_ok) req = q_valid & ~last_open & fits;
    end
  end

  gfa_prio_pick #(.N(NPRIO)) u_pick (
    .req   (req),
    .any   (pick_any),
    .onehot(pick_oh)
  );

  always_comb begin
    sel_wt = '0;
    for (int p = 0; p < NPRIO; p++) begin
      if (pick_oh[p]) sel_wt = sel_wt | wt[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= '0;
      start <= 1'b0;
      grant <= '0;
    end else begin
      start <= pick_any;
      grant <= pick_any ? pick_oh : '0;
      if (pick_any)          busy <= sel_wt - WT_W'(1);
      else if (busy != '0)   busy <= busy - WT_W'(1);
    end
  end

  AST_GRANT_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    start |-> ($countones(grant) == 1)); // R4
  AST_GRANT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !start |-> (grant == '0)); // R4
  AST_WIRE_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy != '0) |=> !start); // R5
  AST_NO_START_AT_FETCH: assert property (@(posedge clk) disable iff (rst)
    (rem == '0) |=> !start); // R3
  AST_WINDOW_MASK: assert property (@(posedge clk) disable iff (rst)
    (start && $past(cur_allow != '0)) |-> ((grant & $past(cur_allow)) != '0)); // R3
  AST_FILL_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (start && $past(cur_allow == '0)) |-> $past(fill_en)); // R7
  AST_FILL_ONE_CLASS: assert property (@(posedge clk) disable iff (rst)
    (start && $past(cur_allow == '0)) |-> $past(single_class)); // R9
  AST_FILL_NOT_TIMED: assert property (@(posedge clk) disable iff (rst)
    (start && $past(cur_allow == '0)) |-> ((grant & $past(last_open)) == '0)); // R8

endmodule

// File: tb/tb_gate_fill_arb.sv
module tb_gate_fill_arb;

  localparam int CLK_PERIOD = 10;
  localparam int NPRIO      = 8;
  localparam int CNT_W      = 16;
  localparam int LEN_W      = 11;
  localparam int MARGIN_W   = 10;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   fetch_req;
  logic [CNT_W-1:0]       ent_count = '0;
  logic [NPRIO-1:0]       ent_allow = '0;
  logic [NPRIO-1:0]       q_valid = '0;
  logic [NPRIO*LEN_W-1:0] q_len = '0;
  logic [1:0]             link_speed = 2'd0;
  logic                   fill_en = 1'b0;
  logic [MARGIN_W-1:0]    fill_margin = '0;
  logic [NPRIO-1:0]       express_mask = 8'h0F;
  logic [NPRIO-1:0]       grant;
  logic                   start;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_fill_arb #(.NPRIO(NPRIO), .CNT_W(CNT_W), .LEN_W(LEN_W), .MARGIN_W(MARGIN_W)) dut (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .ent_count(ent_count),
    .ent_allow(ent_allow), .q_valid(q_valid), .q_len(q_len),
    .link_speed(link_speed), .fill_en(fill_en), .fill_margin(fill_margin),
    .express_mask(express_mask), .grant(grant), .start(start)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_len(input int p, input int len);
    q_len[p*LEN_W +: LEN_W] = LEN_W'(len);
  endtask

  task automatic set_all_len(input int len);
    for (int p = 0; p < NPRIO; p++) set_len(p, len);
  endtask

  // Present an entry at the next fetch; returns at the negedge after the load.
  task automatic load_entry(input int cnt, input logic [7:0] allow, input logic [7:0] qv);
    @(negedge clk);
    while (!fetch_req) @(negedge clk);
    ent_count = CNT_W'(cnt);
    ent_allow = allow;
    q_valid   = qv;
    @(negedge clk);
    ent_count = '0;
    ent_allow = '0;
  endtask

  task automatic watch(input int n, output int first_i, output int second_i,
                       output logic [7:0] first_g, output int nstarts);
    first_i = -1; second_i = -1; first_g = '0; nstarts = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (start) begin
        if (nstarts == 0) begin first_i = i; first_g = grant; end
        else if (nstarts == 1) second_i = i;
        nstarts++;
      end
    end
  endtask

  task automatic settle(input int n);
    q_valid = '0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(grant == '0, "R1 grant in reset", grant, 0);
    check(!start, "R1 start in reset", start, 0);
    check(fetch_req, "R1 fetch_req in reset", fetch_req, 1);
    rst = 1'b0;
    @(negedge clk);
    check(!start && grant == '0, "R1 idle after reset", start, 0);
  endtask

  task automatic t_sequence();
    int n = 0;
    load_entry(5, 8'h00, 8'h00);
    do begin @(negedge clk); n++; end while (!fetch_req && n < 50);
    check(n == 5, "R2 fetch spacing", n, 5);
  endtask

  task automatic t_window();
    int f, s, k; logic [7:0] g;
    link_speed = 2'd0; set_all_len(30);
    load_entry(100, 8'b0010_0110, 8'b1010_0011);
    watch(60, f, s, g, k);
    check(f == 0, "R3 window start cycle", f, 0);
    check(g == 8'h20, "R3 highest allowed valid wins", g, 8'h20);
    check(s == 50, "R5 spacing at gigabit", s, 50);
    check(k == 2, "R4 start pulse count", k, 2);
    settle(150);
  endtask

  task automatic t_speed(input logic [1:0] spd, input int len, input int cnt, input int w);
    int f, s, k; logic [7:0] g;
    link_speed = spd; set_len(0, len);
    load_entry(cnt, 8'h01, 8'h01);
    watch(w + 10, f, s, g, k);
    check(f == 0 && g == 8'h01, "R6 first start", g, 1);
    check(s == w, "R6 clocks-per-byte spacing", s, w);
    settle(cnt + 20);
    link_speed = 2'd0;
  endtask

  task automatic fill_case(input logic [7:0] prev_allow, input bit en, input int cnt,
                           input int margin, input logic [7:0] qv, input int wcyc,
                           output int f, output int s, output logic [7:0] g, output int k);
    fill_en = en; fill_margin = MARGIN_W'(margin);
    load_entry(10, prev_allow, 8'h00);
    load_entry(cnt, 8'h00, qv);
    watch(wcyc, f, s, g, k);
    settle(cnt + 20);
    fill_en = 1'b0;
  endtask

  task automatic t_fill_off();
    int f, s, k; logic [7:0] g;
    set_all_len(10);
    fill_case(8'h01, 1'b0, 200, 5, 8'h80, 150, f, s, g, k);
    check(k == 0, "R7 no grant with fill disabled", k, 0);
  endtask

  task automatic t_fill_on();
    int f, s, k; logic [7:0] g;
    set_all_len(10);
    fill_case(8'h01, 1'b1, 200, 5, 8'h80, 40, f, s, g, k);
    check(f == 0 && g == 8'h80, "R8 fill granted", g, 8'h80);
    check(s == 30, "R8 R5 fill spacing", s, 30);
    fill_case(8'h01, 1'b1, 35, 5, 8'h80, 40, f, s, g, k);
    check(f == 0 && g == 8'h80, "R8 exact fit admitted", g, 8'h80);
    fill_case(8'h01, 1'b1, 34, 5, 8'h80, 40, f, s, g, k);
    check(k == 0, "R8 one clock short refused", k, 0);
    fill_case(8'h01, 1'b1, 200, 5, 8'h01, 60, f, s, g, k);
    check(k == 0, "R8 timed priority excluded", k, 0);
  endtask

  task automatic t_fill_class();
    int f, s, k; logic [7:0] g;
    set_all_len(10);
    fill_case(8'h11, 1'b1, 200, 5, 8'h80, 60, f, s, g, k);
    check(k == 0, "R9 mixed class no fill", k, 0);
    fill_case(8'h30, 1'b1, 200, 5, 8'h80, 10, f, s, g, k);
    check(f == 0 && g == 8'h80, "R9 preemptable-only fill", g, 8'h80);
  endtask

  task automatic t_fill_prio();
    int f, s, k; logic [7:0] g;
    set_all_len(10); set_len(7, 80);
    fill_case(8'h01, 1'b1, 100, 5, 8'hC0, 10, f, s, g, k);
    check(f == 0 && g == 8'h40, "R10 long high priority skipped", g, 8'h40);
    set_len(7, 10);
    fill_case(8'h01, 1'b1, 100, 5, 8'hC0, 10, f, s, g, k);
    check(f == 0 && g == 8'h80, "R10 highest fitting wins", g, 8'h80);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_sequence();
    t_window();
    t_speed(2'd1, 10, 2000, 300);
    t_speed(2'd2, 0, 2500, 2000);
    t_speed(2'd3, 0, 2500, 2000);
    t_fill_off();
    t_fill_on();
    t_fill_class();
    t_fill_prio();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule